// File: doc/BRIEF.md
# DSI Low-Power Command Packet Formatter

This block sits in front of the command and payload FIFOs of a DSI host controller. A request names a virtual channel, a command class and a byte count. A separate byte stream carries the parameters or payload. The block picks the packet data type from the class and the count. It rejects requests that cannot be encoded. For a long packet, it packs the payload bytes into 32-bit little-endian words and pushes them to the payload FIFO. It then pushes the 32-bit header word to the command FIFO.

Each request ends with a one-cycle done pulse and an error flag. The ECC byte of the header is left at zero, because a later stage fills it in. Both FIFO pushes use valid/ready handshakes. A full FIFO is shown by a low ready.

Command class encoding on `req_class`:
- 0: generic write
- 1: DCS write
- 2: generic read
- 3: DCS read
- 4: set maximum return packet size
- 5, 6, 7: illegal

Top module: `dsi_cmd_packer`

## Requirements
- R1: The header word is formed little-endian from four header bytes: bits [7:0] = {vc[1:0], data_type[5:0]}, bits [23:8] = the two parameter or count bytes, bits [31:24] = 8'h00.
- R2: Generic write (class 0) uses type 0x03, 0x13 or 0x23 for 0, 1 or 2 bytes, and the long type 0x29 for 3 or more bytes.
- R3: DCS write (class 1) uses 0x05 for 1 byte, 0x15 for 2 bytes and the long type 0x39 for 3 or more bytes. A count of 0 is rejected.
- R4: Generic read (class 2) uses 0x04, 0x14 or 0x24 for 0, 1 or 2 parameters. A larger count is rejected.
- R5: DCS read (class 3) requires exactly 1 byte and uses 0x06. Set maximum return size (class 4) requires exactly 2 bytes and uses 0x37. Any other count for these classes is rejected, and classes 5 to 7 are always rejected.
- R6: A request with `req_vc` above 3 is rejected. A rejected request consumes no stream bytes and pushes nothing to either FIFO.
- R7: For a long packet, header bits [15:8] hold the low byte of the count and bits [23:16] hold the high byte.
- R8: For a short packet, header bits [15:8] hold the first stream byte and bits [23:16] hold the second. A byte that is not present is sent as zero. Short packets consume exactly the counted bytes.
- R9: Payload bytes are packed with the first byte in bits [7:0]. The packet uses ceil(count/4) words. The last word is zero above its remaining 1 to 3 bytes.
- R10: All payload words are pushed before the header. `hdr_valid` and `pld_valid` are never high together. Each offered word holds its valid and data until the ready input is high.
- R11: `done` is high for exactly one cycle. For an accepted request it comes in the cycle after the header handshake, with `done_err` low. For a rejected request it comes in the cycle after the request handshake, with `done_err` high. A new request is accepted only after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken on valid |
| req_vc | input | 3 | Virtual channel (values above 3 are illegal) |
| req_class | input | 3 | Command class |
| req_len | input | 16 | Parameter or payload byte count |
| byte_valid | input | 1 | Stream byte offered |
| byte_ready | output | 1 | Stream byte taken |
| byte_data | input | 8 | Stream byte |
| pld_valid | output | 1 | Payload word offered to payload FIFO |
| pld_ready | input | 1 | Payload FIFO not full |
| pld_data | output | 32 | Payload word |
| hdr_valid | output | 1 | Header word offered to command FIFO |
| hdr_ready | input | 1 | Command FIFO not full |
| hdr_data | output | 32 | Header word |
| done | output | 1 | Request finished |
| done_err | output | 1 | Request was rejected |

## Verification
The closing partial payload word and the release of the header can land on adjacent cycles. The bench provokes this by holding the payload and command ready inputs low on two cycles of every three, while payload counts of 5, 7 and 9 bytes leave a partial final word. It judges the result by checking three things:
- the padded word arrives with zeros above its valid bytes;
- no header is taken before the expected word count;
- the header value matches the count.

Rejected requests are judged at the ports: no stream byte may be consumed and no FIFO may be pushed before the error pulse.

// File: rtl/dsi_cmd_packer.sv
module dsi_cmd_packer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [2:0]  req_vc,
  input  logic [2:0]  req_class,
  input  logic [15:0] req_len,
  input  logic        byte_valid,
  output logic        byte_ready,
  input  logic [7:0]  byte_data,
  output logic        pld_valid,
  input  logic        pld_ready,
  output logic [31:0] pld_data,
  output logic        hdr_valid,
  input  logic        hdr_ready,
  output logic [31:0] hdr_data,
  output logic        done,
  output logic        done_err
);

  localparam logic [2:0] CL_GEN_WR = 3'd0;
  localparam logic [2:0] CL_DCS_WR = 3'd1;
  localparam logic [2:0] CL_GEN_RD = 3'd2;
  localparam logic [2:0] CL_DCS_RD = 3'd3;
  localparam logic [2:0] CL_MAXRET = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_COLLECT, S_PUSH, S_HDR, S_FIN} state_t;

  state_t      state;
  logic [1:0]  vc_q;
  logic [5:0]  dt_q;
  logic        long_q;
  logic        err_q;
  logic [15:0] len_q;
  logic [15:0] rem_q;
  logic [1:0]  lane_q;
  logic [31:0] word_q;

  logic [5:0]  sel_dt;
  logic        sel_long;
  logic        sel_bad;

  always_comb begin
    sel_dt   = 6'h00;
    sel_long = 1'b0;
    sel_bad  = 1'b0;
    case (req_class)
      CL_GEN_WR:
        case (req_len)
          16'd0:   sel_dt = 6'h03;
          16'd1:   sel_dt = 6'h13;
          16'd2:   sel_dt = 6'h23;
          default: begin sel_dt = 6'h29; sel_long = 1'b1; end
        endcase
      CL_DCS_WR:
        case (req_len)
          16'd0:   sel_bad = 1'b1;
          16'd1:   sel_dt = 6'h05;
          16'd2:   sel_dt = 6'h15;
          default: begin sel_dt = 6'h39; sel_long = 1'b1; end
        endcase
      CL_GEN_RD:
        case (req_len)
          16'd0:   sel_dt = 6'h04;
          16'd1:   sel_dt = 6'h14;
          16'd2:   sel_dt = 6'h24;
          default: sel_bad = 1'b1;
        endcase
      CL_DCS_RD: begin
        sel_dt  = 6'h06;
        sel_bad = (req_len != 16'd1);
      end
      CL_MAXRET: begin
        sel_dt  = 6'h37;
        sel_bad = (req_len != 16'd2);
      end
      default: sel_bad = 1'b1;
    endcase
    if (req_vc > 3'd3) sel_bad = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      vc_q   <= '0;
      dt_q   <= '0;
      long_q <= 1'b0;
      err_q  <= 1'b0;
      len_q  <= '0;
      rem_q  <= '0;
      lane_q <= '0;
      word_q <= '0;
    end else begin
      case (state)
        S_IDLE:
          if (req_valid) begin
            vc_q   <= req_vc[1:0];
            dt_q   <= sel_dt;
            long_q <= sel_long;
            err_q  <= sel_bad;
            len_q  <= req_len;
            rem_q  <= req_len;
            lane_q <= '0;
            word_q <= '0;
            if (sel_bad)             state <= S_FIN;
            else if (req_len == '0)  state <= S_HDR;
            else                     state <= S_COLLECT;
          end
        S_COLLECT:
          if (byte_valid) begin
            word_q <= word_q | (32'(byte_data) << {lane_q, 3'b000});
            rem_q  <= rem_q - 16'd1;
            lane_q <= lane_q + 2'd1;
            if (long_q) begin
              if (lane_q == 2'd3 || rem_q == 16'd1) state <= S_PUSH;
            end else if (rem_q == 16'd1) begin
              state <= S_HDR;
            end
          end
        S_PUSH:
          if (pld_ready) begin
            word_q <= '0;
            lane_q <= '0;
            state  <= (rem_q == '0) ? S_HDR : S_COLLECT;
          end
        S_HDR:
          if (hdr_ready) state <= S_FIN;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (state == S_IDLE);
  assign byte_ready = (state == S_COLLECT);
  assign pld_valid  = (state == S_PUSH);
  assign pld_data   = word_q;
  assign hdr_valid  = (state == S_HDR);
  assign hdr_data   = {8'h00,
                       long_q ? len_q[15:8] : word_q[15:8],
                       long_q ? len_q[7:0]  : word_q[7:0],
                       vc_q, dt_q};
  assign done       = (state == S_FIN);
  assign done_err   = (state == S_FIN) && err_q;

  logic [15:0] pushed_q;
  always_ff @(posedge clk) begin
    if (!rst_n || state == S_IDLE) pushed_q <= '0;
    else if (pld_valid && pld_ready) pushed_q <= pushed_q + 16'd1;
  end

  AST_ECC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> hdr_data[31:24] == 8'h00); // R1
  AST_PLD_BEFORE_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && long_q |-> 17'(pushed_q) == ((17'(len_q) + 17'd3) >> 2)); // R10
  AST_ONE_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
    !(hdr_valid && pld_valid)); // R10
  AST_PLD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pld_valid && !pld_ready |=> pld_valid && $stable(pld_data)); // R10
  AST_HDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && !hdr_ready |=> hdr_valid && $stable(hdr_data)); // R10
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pld_valid && rem_q == '0 && lane_q != 2'd0 |-> (pld_data >> {lane_q, 3'b000}) == 32'd0); // R9
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_err |-> $past(req_ready)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

endmodule

// File: tb/dsi_cmd_packer_test.sv
module dsi_cmd_packer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, byte_valid = 1'b0, pld_ready = 1'b0, hdr_ready = 1'b0;
  logic [2:0] req_vc = '0, req_class = '0;
  logic [15:0] req_len = '0;
  logic [7:0] byte_data = '0;
  logic req_ready, byte_ready, pld_valid, hdr_valid, done, done_err;
  logic [31:0] pld_data, hdr_data;
  int checks = 0, errors = 0, cycles = 0;

  always #2.5 clk = ~clk;

  dsi_cmd_packer uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vc(req_vc), .req_class(req_class), .req_len(req_len),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
    .pld_valid(pld_valid), .pld_ready(pld_ready), .pld_data(pld_data),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_data(hdr_data),
    .done(done), .done_err(done_err));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bval(int seed, int i);
    return 8'(seed * 29 + i * 37 + 5);
  endfunction

  function automatic logic [7:0] exp_dt(int cls, int len, output logic bad, output logic lng);
    bad = 1'b0; lng = 1'b0;
    case (cls)
      0: if (len < 3) return 8'(8'h03 + 16 * len); else begin lng = 1'b1; return 8'h29; end
      1: if (len == 0) bad = 1'b1; else if (len < 3) return 8'(8'h05 + 16 * (len - 1));
         else begin lng = 1'b1; return 8'h39; end
      2: if (len < 3) return 8'(8'h04 + 16 * len); else bad = 1'b1;
      3: if (len == 1) return 8'h06; else bad = 1'b1;
      4: if (len == 2) return 8'h37; else bad = 1'b1;
      default: bad = 1'b1;
    endcase
    return 8'h00;
  endfunction

  task automatic run(string req, int vc, int cls, int len, int seed, bit stall);
    logic bad, lng;
    logic [7:0] dt;
    logic [31:0] exp_hdr, hdr_got, w;
    logic [31:0] words[$];
    int bi = 0, cyc = 0, nw;
    bit accepted = 0, got_hdr = 0, early_hdr = 0, both = 0, fin = 0, ferr = 0;
    dt = exp_dt(cls, len, bad, lng);
    if (vc > 3) bad = 1'b1;
    hdr_got = '0;
    @(negedge clk);
    req_vc = 3'(vc); req_class = 3'(cls); req_len = 16'(len);
    while (cyc < 400) begin
      req_valid = !accepted;
      if (req_valid && req_ready) accepted = 1;
      pld_ready = stall ? (cyc % 3 == 2) : 1'b1;
      hdr_ready = stall ? (cyc % 3 == 1) : 1'b1;
      byte_valid = 1'b1;
      byte_data = bval(seed, bi);
      if (byte_ready) bi++;
      if (hdr_valid && pld_valid) both = 1;
      if (pld_valid && pld_ready) words.push_back(pld_data);
      if (hdr_valid && hdr_ready) begin
        hdr_got = hdr_data; got_hdr = 1;
        if (words.size() != (lng ? (len + 3) / 4 : 0)) early_hdr = 1;
      end
      @(negedge clk);
      cyc++;
      if (done) begin fin = 1; ferr = done_err; break; end
    end
    req_valid = 1'b0;
    check({req, " done seen"}, 32'(fin), 32'd1);
    check({req, " error flag R11"}, 32'(ferr), 32'(bad));
    check({req, " R10 no overlap"}, 32'(both), 32'd0);
    check({req, " R10 header after payload"}, 32'(early_hdr), 32'd0);
    if (bad) begin
      check({req, " R6 no bytes consumed"}, 32'(bi), 32'd0);
      check({req, " R6 nothing pushed"}, 32'(words.size()) + 32'(got_hdr), 32'd0);
    end else begin
      exp_hdr = {8'h00, 8'h00, 8'h00, 2'(vc), dt[5:0]};
      if (lng) exp_hdr[23:8] = 16'(len);
      else begin
        if (len > 0) exp_hdr[15:8] = bval(seed, 0);
        if (len > 1) exp_hdr[23:16] = bval(seed, 1);
      end
      check({req, " R1 header word"}, hdr_got, exp_hdr);
      check({req, " R8 bytes consumed"}, 32'(bi), 32'(len));
      nw = lng ? (len + 3) / 4 : 0;
      check({req, " R9 word count"}, 32'(words.size()), 32'(nw));
      for (int k = 0; k < nw && k < words.size(); k++) begin
        w = '0;
        for (int j = 0; j < 4; j++)
          if (4 * k + j < len) w[8*j +: 8] = bval(seed, 4 * k + j);
        check({req, " R9 payload word"}, words[k], w);
      end
    end
    @(negedge clk);
    check({req, " R11 single pulse"}, 32'(done), 32'd0);
    check({req, " R11 idle again"}, 32'(req_ready), 32'd1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog R11 actual %0d expected below 100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("reset R11 req_ready", 32'(req_ready), 32'd1);
    check("reset R10 valids", {30'd0, hdr_valid, pld_valid}, 32'd0);
    check("reset R11 done", 32'(done), 32'd0);
    run("R2 gen wr 0", 1, 0, 0, 1, 0);
    run("R2 gen wr 1", 2, 0, 1, 2, 0);
    run("R2 gen wr 2", 3, 0, 2, 3, 0);
    run("R2 R7 gen long 3", 0, 0, 3, 4, 0);
    run("R2 R9 gen long 8", 1, 0, 8, 5, 0);
    run("R3 dcs wr 0", 0, 1, 0, 6, 0);
    run("R3 dcs wr 1", 2, 1, 1, 7, 0);
    run("R3 dcs wr 2", 0, 1, 2, 8, 0);
    run("R3 R9 dcs long 7", 3, 1, 7, 9, 1);
    run("R4 gen rd 0", 0, 2, 0, 10, 0);
    run("R4 gen rd 1", 1, 2, 1, 11, 0);
    run("R4 gen rd 2", 2, 2, 2, 12, 1);
    run("R4 gen rd 3", 0, 2, 3, 13, 0);
    run("R5 dcs rd 1", 1, 3, 1, 14, 0);
    run("R5 dcs rd 2", 1, 3, 2, 15, 0);
    run("R5 maxret 2", 3, 4, 2, 16, 0);
    run("R5 maxret 1", 0, 4, 1, 17, 0);
    run("R5 class 6", 0, 6, 2, 18, 0);
    run("R6 vc 4", 4, 0, 5, 19, 0);
    run("R6 vc 7", 7, 1, 1, 20, 0);
    run("R9 R10 stall long 5", 2, 0, 5, 21, 1);
    run("R9 R10 stall long 9", 1, 1, 9, 22, 1);
    run("R7 long 300", 0, 0, 300, 23, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule